// File: doc/BRIEF.md
# DMA Handshake Timing Controller

This block sequences one peripheral-side DMA transfer for a FIFO port. A pending-transfer input starts a handshake: a request line goes active, an acknowledge line follows after a programmed number of ticks, and one tick later a read or write strobe is pulsed for one or two ticks. All waits count ticks of an internal enable that equals either every clock or every second clock, so the whole block stays in one clock domain.

A 16-bit control word chooses the timing, the strobe style, the request and acknowledge polarities and the interface mode. A new word is staged as soon as it is written, but it becomes active only while the sequencer is idle, so a handshake in flight always finishes with the timing it began with. In processor mode the port-side control pins are released (output enable low) and no handshake is ever started. A software clear input aborts a handshake at any point.

Top module: `dma_hs_ctrl`

## Requirements
- R1: After reset the active control word is 0x0000 (processor mode), every handshake and strobe output is 0 and `pins_oe_o` is 0.
- R2: While bit 10 of the active control word is 0 (processor mode), `xfer_pend` is ignored. `pins_oe_o`, `req_o`, `ack_o`, `rd_stb_o`, `wr_stb_o`, `ds_o` and `rnw_o` all stay 0, whatever the polarity bits hold.
- R3: With bit 10 at 1 (peripheral mode), `pins_oe_o` is 1. A tick that sees `xfer_pend` high in idle asserts the request.
- R4: The acknowledge becomes active exactly D ticks after the request, where D = 2 + the value of bits 7:6 (2, 3, 4 or 5).
- R5: The strobe becomes active one tick after the acknowledge and lasts 1 tick (bit 8 = 0) or 2 ticks (bit 8 = 1). Request and acknowledge both drop on the tick the strobe ends, and the sequencer then spends one more tick before it returns to idle.
- R6: Bit 0 = 0 selects separate strobes: `rd_stb_o` pulses for direction 1 and `wr_stb_o` for direction 0, while `ds_o` and `rnw_o` stay 0. Bit 0 = 1 pulses `ds_o` and drives `rnw_o` with the direction for the whole handshake; `rd_stb_o` and `wr_stb_o` stay 0. At most one strobe is active at a time.
- R7: Bit 4 = 1 makes `req_o` active low, and bit 5 = 1 makes `ack_o` active low. Otherwise they are active high. The inactive level is driven while idle in peripheral mode.
- R8: Bit 9 = 1 makes a tick every second clock, which doubles every duration in R4 and R5 in clocks. Bit 9 = 0 makes every clock a tick.
- R9: A control word written while a handshake is in flight does not alter that handshake. It takes effect for the next one.
- R10: `req_clr` high at a clock edge returns the sequencer to idle at that edge, regardless of tick or state. This drops request, acknowledge and strobes by the next clock, even on the edge where the acknowledge would have risen.
- R11: The direction is taken from `xfer_dir` when the handshake starts. Later changes of `xfer_dir` do not affect the strobe choice or `rnw_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word value |
| xfer_pend | input | 1 | A transfer is waiting |
| xfer_dir | input | 1 | 1 = read from the port, 0 = write to it |
| req_clr | input | 1 | Software clear of the internal request |
| req_o | output | 1 | DMA request, polarity per bit 4 |
| ack_o | output | 1 | DMA acknowledge, polarity per bit 5 |
| rd_stb_o | output | 1 | Read strobe (separate-strobe style) |
| wr_stb_o | output | 1 | Write strobe (separate-strobe style) |
| ds_o | output | 1 | Data strobe (strobe-plus-direction style) |
| rnw_o | output | 1 | Read/not-write line (strobe-plus-direction style) |
| pins_oe_o | output | 1 | Port control pins driven (peripheral mode) |

## Verification
The software clear and the acknowledge edge can land on the same clock. The bench sets the longest delay and counts request-active cycles. It raises `req_clr` on the last cycle before the acknowledge is due, and then expects request and acknowledge both inactive on the next sample, with no strobe afterwards. A second same-cycle case is a control write arriving mid-handshake. That is judged by the running handshake keeping its old delay while the following one uses the new delay.

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl #(
  parameter int CFG_W = 16,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             xfer_pend,
  input  logic             xfer_dir,
  input  logic             req_clr,
  output logic             req_o,
  output logic             ack_o,
  output logic             rd_stb_o,
  output logic             wr_stb_o,
  output logic             ds_o,
  output logic             rnw_o,
  output logic             pins_oe_o
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ACK, S_STB, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       cfg_stg, cfg;
  logic             tog, dir_q;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[CFG_W-1:11], cfg_wdata[3:1]};

  wire       c_style = cfg[0];
  wire       c_reqlo = cfg[1];
  wire       c_acklo = cfg[2];
  wire [1:0] c_dly   = cfg[4:3];
  wire       c_wide  = cfg[5];
  wire       c_div   = cfg[6];
  wire       c_per   = cfg[7];

  wire tick = ~c_div | tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_stg <= '0;
      cfg     <= '0;
      tog     <= 1'b0;
    end else begin
      tog <= ~tog;
      if (cfg_we)
        cfg_stg <= {cfg_wdata[10], cfg_wdata[9], cfg_wdata[8], cfg_wdata[7:6],
                    cfg_wdata[5], cfg_wdata[4], cfg_wdata[0]};
      if (st == S_IDLE) cfg <= cfg_stg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      dir_q <= 1'b0;
    end else if (req_clr) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (c_per && xfer_pend) begin
          st    <= S_REQ;
          cnt   <= '0;
          dir_q <= xfer_dir;
        end
        S_REQ: if (cnt == CNT_W'(c_dly) + CNT_W'(1)) begin
          st  <= S_ACK;
          cnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        S_ACK: begin
          st  <= S_STB;
          cnt <= '0;
        end
        S_STB: if (cnt == CNT_W'(c_wide)) st <= S_DONE;
               else cnt <= cnt + CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  wire hs_req = (st == S_REQ) || (st == S_ACK) || (st == S_STB);
  wire hs_ack = (st == S_ACK) || (st == S_STB);
  wire hs_stb = (st == S_STB);

  assign req_o     = c_per & (hs_req ^ c_reqlo);
  assign ack_o     = c_per & (hs_ack ^ c_acklo);
  assign rd_stb_o  = c_per & ~c_style & hs_stb & dir_q;
  assign wr_stb_o  = c_per & ~c_style & hs_stb & ~dir_q;
  assign ds_o      = c_per & c_style & hs_stb;
  assign rnw_o     = c_per & c_style & dir_q & (st != S_IDLE);
  assign pins_oe_o = c_per;

  wire req_act = c_per & (req_o ^ c_reqlo);
  wire ack_act = c_per & (ack_o ^ c_acklo);
  wire stb_any = rd_stb_o | wr_stb_o | ds_o;

  p_ack_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_act) |-> $past(req_act));
  p_strobe_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_any) |-> $past(ack_act));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb_o, wr_stb_o, ds_o}));
  p_proc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_oe_o |-> !(req_o | ack_o | stb_any | rnw_o));
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(cfg));
  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |=> (st == S_IDLE));
  p_dir_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(dir_q));

endmodule

// File: tb/dma_hs_ctrl_tb.sv
module dma_hs_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, xfer_pend = 1'b0, xfer_dir = 1'b0, req_clr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic req_o, ack_o, rd_stb_o, wr_stb_o, ds_o, rnw_o, pins_oe_o;

  int total = 0, bad = 0;
  logic [15:0] cur = '0;

  always #(CLK_P/2) clk = ~clk;

  dma_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .xfer_pend(xfer_pend), .xfer_dir(xfer_dir), .req_clr(req_clr),
    .req_o(req_o), .ack_o(ack_o), .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o),
    .ds_o(ds_o), .rnw_o(rnw_o), .pins_oe_o(pins_oe_o)
  );

  // {cfg word, dir, req-to-ack clocks, strobe clocks}
  localparam logic [32:0] VEC [6] = '{
    {16'h0400, 1'b1, 8'd2, 8'd1},
    {16'h04C0, 1'b0, 8'd5, 8'd1},
    {16'h0540, 1'b1, 8'd3, 8'd2},
    {16'h0681, 1'b1, 8'd8, 8'd2},
    {16'h0730, 1'b0, 8'd4, 8'd4},
    {16'h0511, 1'b0, 8'd2, 8'd2}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic logic racts();
    return req_o ^ cur[4];
  endfunction
  function automatic logic aacts();
    return ack_o ^ cur[5];
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] w);
    cfg_wdata = w; cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (racts()) begin seen = 1'b1; break; end
      cyc(1);
    end
  endtask

  task automatic count_while_req_only(output int n);
    n = 0;
    while (racts() && !aacts() && n < 60) begin n++; cyc(1); end
  endtask

  task automatic run_vec(input logic [32:0] v);
    logic [15:0] w;
    bit seen, d;
    int k, ra, ap, sl;
    w = v[32:17]; d = v[16];
    k = w[9] ? 2 : 1;
    wr_cfg(w); cyc(3);
    cur = w;
    chk(req_o == w[4], "R7 idle req level", req_o, w[4]);
    chk(ack_o == w[5], "R7 idle ack level", ack_o, w[5]);
    chk(pins_oe_o == 1'b1, "R3 oe in peripheral", pins_oe_o, 1);
    xfer_dir = d; xfer_pend = 1'b1;
    wait_req(seen);
    xfer_pend = 1'b0;
    chk(seen, "R3 request asserted", seen, 1);
    count_while_req_only(ra);
    chk(ra == int'(v[15:8]), "R4/R8 req-to-ack clocks", ra, int'(v[15:8]));
    ap = 0;
    while (aacts() && !(rd_stb_o | wr_stb_o | ds_o) && ap < 20) begin ap++; cyc(1); end
    chk(ap == k, "R5 ack-to-strobe clocks", ap, k);
    if (w[0]) begin
      chk(ds_o && !rd_stb_o && !wr_stb_o, "R6 data strobe style", {rd_stb_o, wr_stb_o, ds_o}, 1);
      chk(rnw_o == d, "R6 rnw follows dir", rnw_o, d);
    end else begin
      chk(rd_stb_o == d && wr_stb_o == !d && !ds_o && !rnw_o, "R6 separate strobes",
          {rd_stb_o, wr_stb_o, ds_o, rnw_o}, {d, !d, 2'b00});
    end
    sl = 0;
    while ((rd_stb_o | wr_stb_o | ds_o) && sl < 20) begin sl++; cyc(1); end
    chk(sl == int'(v[7:0]), "R5/R8 strobe clocks", sl, int'(v[7:0]));
    chk(!racts() && !aacts(), "R5 req/ack drop with strobe", {racts(), aacts()}, 0);
    cyc(6);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int ra;
    cyc(2);
    chk({req_o, ack_o, rd_stb_o, wr_stb_o, ds_o, rnw_o, pins_oe_o} == 0, "R1 reset outputs",
        {req_o, ack_o, rd_stb_o, wr_stb_o, ds_o, rnw_o, pins_oe_o}, 0);
    rst_n = 1'b1;
    cyc(2);
    chk({req_o, ack_o, pins_oe_o} == 0, "R1 after release", {req_o, ack_o, pins_oe_o}, 0);

    // R2: processor mode ignores pending, polarity bits ignored
    wr_cfg(16'h0031); cyc(2);
    xfer_pend = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (req_o | ack_o | rd_stb_o | wr_stb_o | ds_o | rnw_o | pins_oe_o) seen = 1'b1;
      cyc(1);
    end
    xfer_pend = 1'b0;
    chk(!seen, "R2 processor mode quiet", seen, 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R9 + R11: new word mid-handshake, dir changed mid-handshake
    wr_cfg(16'h0400); cyc(3); cur = 16'h0400;
    xfer_dir = 1'b1; xfer_pend = 1'b1;
    wait_req(seen);
    xfer_pend = 1'b0; xfer_dir = 1'b0;
    cfg_wdata = 16'h04C0; cfg_we = 1'b1;
    cyc(1); cfg_we = 1'b0;
    count_while_req_only(ra);
    chk(ra == 1, "R9 running handshake keeps delay 2", ra + 1, 2);
    cyc(1);
    chk(rd_stb_o && !wr_stb_o, "R11 latched direction", {rd_stb_o, wr_stb_o}, 2);
    cyc(6);
    xfer_pend = 1'b1;
    wait_req(seen);
    xfer_pend = 1'b0;
    count_while_req_only(ra);
    chk(ra == 5, "R9 next handshake uses delay 5", ra, 5);
    cyc(8);

    // R10: clear on the edge where ack would rise (delay 5)
    xfer_pend = 1'b1;
    wait_req(seen);
    xfer_pend = 1'b0;
    cyc(4);
    chk(racts() && !aacts(), "R10 still in request", {racts(), aacts()}, 2);
    req_clr = 1'b1;
    cyc(1);
    req_clr = 1'b0;
    chk(!racts() && !aacts(), "R10 clear beats ack", {racts(), aacts()}, 0);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (racts() | rd_stb_o | wr_stb_o | ds_o) seen = 1'b1;
      cyc(1);
    end
    chk(!seen, "R10 no strobe after clear", seen, 0);

    // R10: clear while idle with pending drops the start for that edge
    xfer_pend = 1'b1; req_clr = 1'b1;
    cyc(1);
    chk(!racts(), "R10 clear holds idle", racts(), 0);
    req_clr = 1'b0; xfer_pend = 1'b0;
    cyc(12);

    // R2: back to processor mode releases pins
    wr_cfg(16'h0000); cyc(3);
    chk(pins_oe_o == 1'b0 && req_o == 1'b0, "R2 oe released", {pins_oe_o, req_o}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule